// File: doc/BRIEF.md
# Saturating Up/Down Counter Field

This block is one counting field of a control/status register bank. Hardware raises an increment strobe or a decrement strobe, and the stored value moves up or down by a step. Each step is either a build-time constant, which is 1 unless set otherwise, or a value taken from an input port.

Each direction is configured on its own. A direction can saturate at its own limit or wrap around the field width. When a direction wraps, the block reports overflow (up) or underflow (down) during the cycle in which the wrap happens. Two threshold flags compare the stored value against a configurable level in each direction. Two saturation flags show that the value sits at a limit.

A software load of a new value may arrive in the same cycle as the strobes. The load sets the starting candidate value. The increment is applied to that candidate first and the decrement second. If the final candidate lies outside a saturating limit, it is clamped to that limit before it is stored. This clamping applies whatever the cause, including a loaded value.

Top module: `sat_updown_field`

## Requirements
- R1: While `rst_n` is low at a clock edge, the field takes `RESET_VAL`. All flags are computed combinationally from the stored value, the strobes and the load inputs.
- R2: The step source is set per direction by a parameter. With `STEP_CONST` (encoding 0), the step is `INC_CONST` or `DEC_CONST`, each of which defaults to 1. With `STEP_PORT` (encoding 1), the step is `inc_step_i` or `dec_step_i`.
- R3: In saturating up mode, the sum is formed one bit wider than the field. If the sum is greater than `UP_LIMIT` (default all ones), the value becomes `UP_LIMIT`. `up_sat_o` is 1 whenever the stored value is greater than or equal to `UP_LIMIT`.
- R4: In wrapping up mode, the value becomes the sum modulo 2^W. `overflow_o` is 1 only in a cycle with `inc_i` high in which the widened sum exceeds the all-ones value.
- R5: In saturating down mode, if the candidate is less than the step plus `DN_LIMIT` (default 0), the value becomes `DN_LIMIT`. Otherwise the step is subtracted. `dn_sat_o` is 1 whenever the stored value is less than or equal to `DN_LIMIT`.
- R6: In wrapping down mode, the value becomes the difference modulo 2^W. `underflow_o` is 1 only in a cycle with `dec_i` high in which the candidate is less than the step.
- R7: `inc_thr_o` is 1 when the stored value is greater than or equal to `UP_THRESH` (default all ones). `dec_thr_o` is 1 when the stored value is less than or equal to `DN_THRESH` (default 0).
- R8: When `load_i` is high, `load_val_i` replaces the stored value as the starting candidate. Within one cycle, the increment is applied before the decrement.
- R9: A final candidate above a saturating `UP_LIMIT`, or below a saturating `DN_LIMIT`, is clamped to that limit. This covers a loaded value with no strobe.
- R10: With no load and no strobe, the stored value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Software load strobe |
| load_val_i | input | W | Value to load |
| inc_i | input | 1 | Increment strobe |
| inc_step_i | input | W | Increment step (used in port step mode) |
| dec_i | input | 1 | Decrement strobe |
| dec_step_i | input | W | Decrement step (used in port step mode) |
| value_o | output | W | Stored field value |
| inc_thr_o | output | 1 | Value is at or above the up threshold |
| dec_thr_o | output | 1 | Value is at or below the down threshold |
| up_sat_o | output | 1 | Value is at or above the up limit (saturating up mode only) |
| dn_sat_o | output | 1 | Value is at or below the down limit (saturating down mode only) |
| overflow_o | output | 1 | The increment wraps in this cycle |
| underflow_o | output | 1 | The decrement wraps in this cycle |

## Verification
The bench builds two 8-bit copies of the block and drives them from the same inputs.

The first copy takes both steps from the ports. It saturates up at 200 with an up threshold of 150, and saturates down at 10 with a down threshold of 20. This reaches the clamping of loads above and below the limits, and the increment-before-decrement ordering, where a clamp between the two stages changes the result.

The second copy uses constant steps of 3 up and the default 1 down, wraps in both directions, and keeps the default thresholds. This reaches overflow, underflow, and the default step and threshold values.

// File: rtl/ctr_field_pkg.sv
`timescale 1ns/1ps
// Shared types for the counter field: selects where each direction's step comes from.
package ctr_field_pkg;
    typedef enum logic {
        STEP_CONST = 1'b0,
        STEP_PORT  = 1'b1
    } step_src_e;
endpackage

// File: rtl/ctr_up_stage.sv
`timescale 1ns/1ps
// Increment stage: adds a step to a candidate value.
// Assumes the step is already selected. SAT picks saturate-at-LIMIT or wrap with overflow.
module ctr_up_stage #(
    parameter int unsigned W     = 8,
    parameter bit          SAT   = 1'b1,
    parameter logic [W-1:0] LIMIT = '1
) (
    input  logic         en_i,
    input  logic [W-1:0] cand_i,
    input  logic [W-1:0] step_i,
    output logic [W-1:0] cand_o,
    output logic         ovf_o
);
    logic [W:0] sum;

    // Widened sum so the carry out stays visible.
    always_comb sum = {1'b0, cand_i} + {1'b0, step_i};

    generate
        if (SAT) begin : g_sat
            // Saturating add: the result never goes past LIMIT.
            always_comb begin
                ovf_o = 1'b0;
                if (!en_i)                    cand_o = cand_i;
                else if (sum > {1'b0, LIMIT}) cand_o = LIMIT;
                else                          cand_o = sum[W-1:0];
            end
        end else begin : g_wrap
            // Wrapping add: the carry out is reported as overflow.
            always_comb begin
                cand_o = en_i ? sum[W-1:0] : cand_i;
                ovf_o  = en_i & sum[W];
            end
        end
    endgenerate
endmodule

// File: rtl/ctr_dn_stage.sv
`timescale 1ns/1ps
// Decrement stage: subtracts a step from the candidate left by the increment stage.
// SAT picks saturate-at-LIMIT or wrap with underflow.
module ctr_dn_stage #(
    parameter int unsigned W     = 8,
    parameter bit          SAT   = 1'b1,
    parameter logic [W-1:0] LIMIT = '0
) (
    input  logic         en_i,
    input  logic [W-1:0] cand_i,
    input  logic [W-1:0] step_i,
    output logic [W-1:0] cand_o,
    output logic         unf_o
);
    logic [W:0] floor_need;

    // Smallest candidate that can take a full step and stay at or above LIMIT.
    always_comb floor_need = {1'b0, step_i} + {1'b0, LIMIT};

    generate
        if (SAT) begin : g_sat
            // Saturating subtract: the result never goes below LIMIT.
            always_comb begin
                unf_o = 1'b0;
                if (!en_i)                          cand_o = cand_i;
                else if ({1'b0, cand_i} < floor_need) cand_o = LIMIT;
                else                                cand_o = cand_i - step_i;
            end
        end else begin : g_wrap
            // Wrapping subtract: a borrow is reported as underflow.
            always_comb begin
                cand_o = en_i ? (cand_i - step_i) : cand_i;
                unf_o  = en_i & (cand_i < step_i);
            end
        end
    endgenerate
endmodule

// File: rtl/sat_updown_field.sv
`timescale 1ns/1ps
// Up/down counter register field.
// Order of work in one cycle: load -> increment -> decrement -> clamp to saturating limits.
// Assumes DN_LIMIT <= UP_LIMIT when both directions saturate.
// Flags are combinational from the stored value and the current inputs.
module sat_updown_field #(
    parameter int unsigned              W         = 8,
    parameter ctr_field_pkg::step_src_e INC_SRC   = ctr_field_pkg::STEP_CONST,
    parameter ctr_field_pkg::step_src_e DEC_SRC   = ctr_field_pkg::STEP_CONST,
    parameter logic [W-1:0]             INC_CONST = 1,
    parameter logic [W-1:0]             DEC_CONST = 1,
    parameter bit                       UP_SAT    = 1'b1,
    parameter bit                       DN_SAT    = 1'b1,
    parameter logic [W-1:0]             UP_LIMIT  = '1,
    parameter logic [W-1:0]             DN_LIMIT  = '0,
    parameter logic [W-1:0]             UP_THRESH = '1,
    parameter logic [W-1:0]             DN_THRESH = '0,
    parameter logic [W-1:0]             RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         inc_i,
    input  logic [W-1:0] inc_step_i,
    input  logic         dec_i,
    input  logic [W-1:0] dec_step_i,
    output logic [W-1:0] value_o,
    output logic         inc_thr_o,
    output logic         dec_thr_o,
    output logic         up_sat_o,
    output logic         dn_sat_o,
    output logic         overflow_o,
    output logic         underflow_o
);
    import ctr_field_pkg::*;

    logic [W-1:0] value_q;
    logic [W-1:0] cand_ld, cand_up, cand_dn, cand_hi, cand_fin;
    logic [W-1:0] inc_step, dec_step;

    // Step selection for each direction: build-time constant or port.
    always_comb begin
        inc_step = (INC_SRC == STEP_PORT) ? inc_step_i : INC_CONST;
        dec_step = (DEC_SRC == STEP_PORT) ? dec_step_i : DEC_CONST;
    end

    // A software load replaces the stored value as the starting candidate.
    always_comb cand_ld = load_i ? load_val_i : value_q;

    ctr_up_stage #(.W(W), .SAT(UP_SAT), .LIMIT(UP_LIMIT)) u_up (
        .en_i   (inc_i),
        .cand_i (cand_ld),
        .step_i (inc_step),
        .cand_o (cand_up),
        .ovf_o  (overflow_o)
    );

    ctr_dn_stage #(.W(W), .SAT(DN_SAT), .LIMIT(DN_LIMIT)) u_dn (
        .en_i   (dec_i),
        .cand_i (cand_up),
        .step_i (dec_step),
        .cand_o (cand_dn),
        .unf_o  (underflow_o)
    );

    // Clamp the final candidate into the saturating limits.
    generate
        if (UP_SAT) begin : g_clamp_hi
            always_comb cand_hi = (cand_dn > UP_LIMIT) ? UP_LIMIT : cand_dn;
        end else begin : g_pass_hi
            always_comb cand_hi = cand_dn;
        end
        if (DN_SAT) begin : g_clamp_lo
            always_comb cand_fin = (cand_hi < DN_LIMIT) ? DN_LIMIT : cand_hi;
        end else begin : g_pass_lo
            always_comb cand_fin = cand_hi;
        end
    endgenerate

    // Field storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) value_q <= RESET_VAL;
        else        value_q <= cand_fin;
    end

    // Status flags derived from the stored value.
    always_comb begin
        value_o   = value_q;
        inc_thr_o = (value_q >= UP_THRESH);
        dec_thr_o = (value_q <= DN_THRESH);
        up_sat_o  = UP_SAT && (value_q >= UP_LIMIT);
        dn_sat_o  = DN_SAT && (value_q <= DN_LIMIT);
    end
endmodule

// File: rtl/sat_updown_field_chk.sv
`timescale 1ns/1ps
// Property checker for the counter field, attached to every instance by bind.
module sat_updown_field_chk #(
    parameter int unsigned  W        = 8,
    parameter bit           UP_SAT   = 1'b1,
    parameter bit           DN_SAT   = 1'b1,
    parameter logic [W-1:0] UP_LIMIT = '1,
    parameter logic [W-1:0] DN_LIMIT = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_i,
    input logic         inc_i,
    input logic         dec_i,
    input logic [W-1:0] value_o,
    input logic         up_sat_o,
    input logic         overflow_o,
    input logic         underflow_o
);
    AST_CEILING_HELD:  assert property (@(posedge clk) disable iff (!rst_n)
        UP_SAT |=> (value_o <= UP_LIMIT));                                     // R9
    AST_FLOOR_HELD:    assert property (@(posedge clk) disable iff (!rst_n)
        DN_SAT |=> (value_o >= DN_LIMIT));                                     // R9
    AST_OVF_NEEDS_INC: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> inc_i);                                                 // R4
    AST_UNF_NEEDS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> dec_i);                                                // R6
    AST_IDLE_HOLDS:    assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !dec_i && !load_i) |=> $stable(value_o));                  // R10
    AST_SAT_STAYS:     assert property (@(posedge clk) disable iff (!rst_n)
        (up_sat_o && inc_i && !dec_i && !load_i) |=> up_sat_o);               // R3
endmodule

bind sat_updown_field sat_updown_field_chk #(
    .W(W), .UP_SAT(UP_SAT), .DN_SAT(DN_SAT), .UP_LIMIT(UP_LIMIT), .DN_LIMIT(DN_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .inc_i(inc_i), .dec_i(dec_i),
    .value_o(value_o), .up_sat_o(up_sat_o), .overflow_o(overflow_o),
    .underflow_o(underflow_o)
);

// File: tb/tb_sat_updown_field.sv
`timescale 1ns/1ps
module tb_sat_updown_field;
    import ctr_field_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_i = 1'b0, inc_i = 1'b0, dec_i = 1'b0;
    logic [7:0] load_val_i = '0, inc_step_i = '0, dec_step_i = '0;

    logic [7:0] a_val, b_val;
    logic a_it, a_dt, a_us, a_ds, a_ov, a_un;
    logic b_it, b_dt, b_us, b_ds, b_ov, b_un;

    always #2.5 clk = ~clk;

    // Copy A: port steps, both directions saturating.
    sat_updown_field #(.W(8), .INC_SRC(STEP_PORT), .DEC_SRC(STEP_PORT),
        .UP_SAT(1'b1), .DN_SAT(1'b1), .UP_LIMIT(8'd200), .DN_LIMIT(8'd10),
        .UP_THRESH(8'd150), .DN_THRESH(8'd20), .RESET_VAL(8'd50)) dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(load_val_i),
        .inc_i(inc_i), .inc_step_i(inc_step_i), .dec_i(dec_i), .dec_step_i(dec_step_i),
        .value_o(a_val), .inc_thr_o(a_it), .dec_thr_o(a_dt), .up_sat_o(a_us),
        .dn_sat_o(a_ds), .overflow_o(a_ov), .underflow_o(a_un));

    // Copy B: constant steps (3 up, default 1 down), both directions wrapping.
    sat_updown_field #(.W(8), .INC_CONST(8'd3), .UP_SAT(1'b0), .DN_SAT(1'b0)) dut_wrap (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(load_val_i),
        .inc_i(inc_i), .inc_step_i(inc_step_i), .dec_i(dec_i), .dec_step_i(dec_step_i),
        .value_o(b_val), .inc_thr_o(b_it), .dec_thr_o(b_dt), .up_sat_o(b_us),
        .dn_sat_o(b_ds), .overflow_o(b_ov), .underflow_o(b_un));

    typedef struct {
        string      tag;
        logic [7:0] a_v, b_v;
        logic       a_o, a_u, b_o, b_u;
    } exp_t;
    exp_t sb[$];

    int n_chk = 0, n_fail = 0;
    int ma = 50, mb = 0;
    bit done = 1'b0;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reference model of one cycle, written from the requirements.
    task automatic model(input int cur, input bit ld, input int lv, input bit inc, input bit dec,
                         input int si, input int sd, input bit us, input int ul,
                         input bit ds, input int dl, output int nxt, output bit ov, output bit un);
        int c;
        c = ld ? lv : cur;
        ov = 0; un = 0;
        if (inc) begin
            if (us) c = (c + si > ul) ? ul : c + si;
            else begin ov = (c + si > 255); c = (c + si) % 256; end
        end
        if (dec) begin
            if (ds) c = (c < sd + dl) ? dl : c - sd;
            else begin un = (c < sd); c = (c - sd + 256) % 256; end
        end
        if (us && c > ul) c = ul;
        if (ds && c < dl) c = dl;
        nxt = c;
    endtask

    // Driver: applies one cycle of stimulus and queues the expected result.
    task automatic drive(string tag, bit ld, int lv, bit inc, bit dec, int si, int sd);
        exp_t e;
        int na, nb;
        bit oa, ua, ob, ub;
        @(posedge clk); #1;
        load_i = ld; load_val_i = lv[7:0]; inc_i = inc; dec_i = dec;
        inc_step_i = si[7:0]; dec_step_i = sd[7:0];
        model(ma, ld, lv, inc, dec, si, sd, 1'b1, 200, 1'b1, 10, na, oa, ua);
        model(mb, ld, lv, inc, dec, 3, 1, 1'b0, 255, 1'b0, 0, nb, ob, ub);
        e.tag = tag; e.a_v = na[7:0]; e.b_v = nb[7:0];
        e.a_o = oa; e.a_u = ua; e.b_o = ob; e.b_u = ub;
        sb.push_back(e);
        ma = na; mb = nb;
    endtask

    // Monitor: wrap flags at mid-cycle, stored value and its flags just after the edge.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                e = sb.pop_front();
                chk(e.tag, "A overflow", a_ov, e.a_o);
                chk(e.tag, "A underflow", a_un, e.a_u);
                chk(e.tag, "B overflow", b_ov, e.b_o);
                chk(e.tag, "B underflow", b_un, e.b_u);
                @(posedge clk); #0.5;
                chk(e.tag, "A value", a_val, e.a_v);
                chk(e.tag, "B value", b_val, e.b_v);
                chk(e.tag, "A inc_thr", a_it, e.a_v >= 150);
                chk(e.tag, "A dec_thr", a_dt, e.a_v <= 20);
                chk(e.tag, "A up_sat", a_us, e.a_v >= 200);
                chk(e.tag, "A dn_sat", a_ds, e.a_v <= 10);
                chk(e.tag, "B inc_thr", b_it, e.b_v == 255);
                chk(e.tag, "B dec_thr", b_dt, e.b_v == 0);
                chk(e.tag, "B sat flags", {b_us, b_ds}, 0);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "A reset value", a_val, 50);
        chk("R1", "B reset value", b_val, 0);
        rst_n = 1'b1;
        drive("R1_idle", 0, 0, 0, 0, 0, 0);
        drive("R10_hold", 0, 0, 0, 0, 77, 77);
        // R2 R3 R7: port step 40 climbs A; B adds its constant 3.
        drive("R3_up", 0, 0, 1, 0, 40, 0);
        drive("R7_thr", 0, 0, 1, 0, 40, 0);
        drive("R7_thr", 0, 0, 1, 0, 40, 0);
        drive("R3_sat", 0, 0, 1, 0, 40, 0);
        drive("R3_sat_stay", 0, 0, 1, 0, 40, 0);
        // R5: A falls by 100, then saturates at 10. R6 B decrements by default step 1.
        drive("R5_dn", 0, 0, 0, 1, 0, 100);
        drive("R5_sat", 0, 0, 0, 1, 0, 100);
        // R6: B wraps below zero, R4: B wraps above 255.
        drive("R6_prep", 1, 1, 0, 0, 0, 0);
        drive("R6_unf", 0, 0, 0, 1, 0, 5);
        drive("R6_unf", 0, 0, 0, 1, 0, 5);
        drive("R4_prep", 1, 254, 0, 0, 0, 0);
        drive("R4_ovf", 0, 0, 1, 0, 1, 0);
        drive("R4_no_inc", 0, 0, 0, 0, 0, 0);
        // R9: loads beyond the limits are clamped.
        drive("R9_hi", 1, 250, 0, 0, 0, 0);
        drive("R9_lo", 1, 3, 0, 0, 0, 0);
        // R8: load then increment then decrement in one cycle.
        drive("R8_mix", 1, 100, 1, 1, 50, 30);
        drive("R8_order", 1, 195, 1, 1, 20, 20);
        drive("R8_order_dn", 1, 12, 1, 1, 0, 5);
        for (int i = 0; i < 300; i++)
            drive("R8_rand", ($urandom % 4) == 0, $urandom % 256, $urandom % 2,
                  $urandom % 2, $urandom % 64, $urandom % 64);
        drive("R10_hold", 0, 0, 0, 0, 0, 0);
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule